// File: doc/BRIEF.md
# Hop-Count Buffer Slot Allocator

This block keeps the packet buffers of one router node in a deadlock-free arrangement. The node owns one buffer slot per possible hop count, from zero up to the largest hop count a minimum-hop route can reach. A packet's hop count picks its slot. A packet that has travelled `h` hops and is offered by a neighbour may only land in slot `h+1`, and only if that slot holds nothing. A freshly created local packet may only land in slot 0. Because a packet can only climb to a higher slot, the waits between buffers can never form a cycle.

Each clock cycle the block accepts up to three requests: a local generation, an arrival from a neighbour carrying its hop field, and a local consumption naming a slot. Each request is answered one cycle later by a grant or a reject pulse. Every decision uses only the node's own occupancy and the hop field carried by the packet. A free vector and a probe port let an upstream node ask whether the slot for a given hop index is empty before it forwards. Route choice and link transfer are handled outside this block.

Top module: `hop_slot_alloc`

## Requirements
- R1: While reset is held and in the first cycle after it, every bit of `free_vec` is 1 and no grant, reject or error pulse is asserted.
- R2: A generation request is granted exactly when slot 0 is free. The payload is then stored in slot 0 and `free_vec[0]` drops to 0. Otherwise it is rejected.
- R3: An arrival with hop field `h`, where `h` < `HOP_MAX`, is granted exactly when slot `h+1` is free. The payload is then stored in slot `h+1`. Otherwise it is rejected with no change to occupancy.
- R4: An arrival with hop field `h` >= `HOP_MAX` is rejected and `hop_err` pulses with the reject. Occupancy is unchanged.
- R5: A consumption request naming an occupied slot is always granted, whatever else is requested in the same cycle. That slot becomes free.
- R6: A consumption request naming an empty slot, or a slot index >= `HOP_MAX+1`, is rejected and changes nothing.
- R7: Consumption is applied before admission. A slot freed by a consumption in a cycle can be granted to a generation or an arrival in that same cycle.
- R8: Each request at a rising edge produces exactly one of grant or reject, held high for exactly the following cycle. A cycle with no request gives no pulse.
- R9: `probe_free` equals bit `probe_idx` of `free_vec`, which is 1 for an empty slot. It reflects the occupancy registered at the last edge.
- R10: A generation and an arrival in the same cycle are decided independently, because they always target different slots.
- R11: On a consumption grant, `con_data` carries the payload that was written into that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_req | input | 1 | Local packet creation request |
| gen_data | input | PAYLOAD_W | Payload of the created packet |
| arr_req | input | 1 | Packet offered by a neighbour |
| arr_hop | input | SLOT_W | Hops already taken by the offered packet |
| arr_data | input | PAYLOAD_W | Payload of the offered packet |
| con_req | input | 1 | Local consumption request |
| con_slot | input | SLOT_W | Slot to consume |
| probe_idx | input | SLOT_W | Slot index queried by upstream |
| gen_grant | output | 1 | Generation accepted |
| gen_reject | output | 1 | Generation refused |
| arr_grant | output | 1 | Arrival accepted |
| arr_reject | output | 1 | Arrival refused |
| hop_err | output | 1 | Arrival refused for an out-of-range hop field |
| con_grant | output | 1 | Consumption accepted |
| con_reject | output | 1 | Consumption refused |
| con_data | output | PAYLOAD_W | Payload of the consumed slot, valid with `con_grant` |
| free_vec | output | HOP_MAX+1 | One bit per slot, 1 when empty |
| probe_free | output | 1 | Emptiness of slot `probe_idx` |

## Verification
The hardest case to reach is a full slot that is both emptied and refilled in one cycle. A consumption must target exactly the slot that a generation or arrival wants in that same cycle. The stimulus first fills slot 0 and a mid slot. It then issues a consumption together with a generation, and separately a consumption together with an arrival whose hop field is one below the consumed slot. It checks that both requests are granted and that the slot stays occupied with the new payload. A long stretch of mixed random requests, compared each cycle against a behavioural model, then covers the remaining combinations.

// File: rtl/hop_slot_pkg.sv
package hop_slot_pkg;

    localparam int DEF_HOP_MAX   = 4;
    localparam int DEF_PAYLOAD_W = 16;

    typedef struct packed {
        logic grant;
        logic reject;
    } verdict_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_GEN  = 2'd1,
        SRC_ARR  = 2'd2
    } wsrc_e;

    function automatic verdict_t decide(input logic req, input logic ok);
        verdict_t v;
        v.grant  = req & ok;
        v.reject = req & ~ok;
        return v;
    endfunction

endpackage

// File: rtl/hop_admit.sv
module hop_admit
    import hop_slot_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_HOP_MAX + 1,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] occ,
    input  logic                 gen_req,
    input  logic                 arr_req,
    input  logic [SLOT_W-1:0]    arr_hop,
    input  logic                 con_req,
    input  logic [SLOT_W-1:0]    con_slot,
    output verdict_t             gen_v,
    output verdict_t             arr_v,
    output verdict_t             con_v,
    output logic                 hop_bad,
    output logic [NUM_SLOTS-1:0] clr,
    output wsrc_e                wsrc [NUM_SLOTS]
);

    logic                 con_in_range;
    logic [NUM_SLOTS-1:0] avail;
    logic [NUM_SLOTS-1:0] arr_hit;
    logic                 gen_ok;
    logic                 arr_ok;

    always_comb begin
        con_in_range = int'(con_slot) < NUM_SLOTS;
        hop_bad      = arr_req && (int'(arr_hop) >= NUM_SLOTS - 1);
        for (int i = 0; i < NUM_SLOTS; i++) begin
            clr[i]     = con_req && con_in_range && (int'(con_slot) == i) && occ[i];
            avail[i]   = ~occ[i] | clr[i];
            arr_hit[i] = arr_req && !hop_bad && (i > 0) && (int'(arr_hop) + 1 == i);
        end
        gen_ok = avail[0];
        arr_ok = |(arr_hit & avail);
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (i == 0 && gen_req && gen_ok)
                wsrc[i] = SRC_GEN;
            else if (arr_hit[i] && avail[i])
                wsrc[i] = SRC_ARR;
            else
                wsrc[i] = SRC_NONE;
        end
        gen_v = decide(gen_req, gen_ok);
        arr_v = decide(arr_req, arr_ok);
        con_v = decide(con_req, |clr);
    end

    // R6: a slot is only released if it was holding a packet
    always_comb begin
        p_clear_only_full_r6: assert ((clr & ~occ) == '0);
    end

endmodule

// File: rtl/hop_slot_bank.sv
module hop_slot_bank
    import hop_slot_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_HOP_MAX + 1,
    parameter int PAYLOAD_W = DEF_PAYLOAD_W
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_SLOTS-1:0]                clr,
    input  wsrc_e                               wsrc [NUM_SLOTS],
    input  logic [PAYLOAD_W-1:0]                gen_data,
    input  logic [PAYLOAD_W-1:0]                arr_data,
    output logic [NUM_SLOTS-1:0]                occ,
    output logic [NUM_SLOTS-1:0][PAYLOAD_W-1:0] slot_data
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic                 occ_q;
        logic [PAYLOAD_W-1:0] data_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                occ_q  <= 1'b0;
                data_q <= '0;
            end else begin
                unique case (wsrc[g])
                    SRC_GEN: begin
                        occ_q  <= 1'b1;
                        data_q <= gen_data;
                    end
                    SRC_ARR: begin
                        occ_q  <= 1'b1;
                        data_q <= arr_data;
                    end
                    default: begin
                        if (clr[g])
                            occ_q <= 1'b0;
                    end
                endcase
            end
        end

        assign occ[g]       = occ_q;
        assign slot_data[g] = data_q;

        // R3: a write never lands on a slot that stays occupied
        p_write_needs_room_r3: assert property (@(posedge clk) disable iff (rst)
            (wsrc[g] != SRC_NONE) |-> (!occ_q || clr[g]));
    end

endmodule

// File: rtl/hop_slot_alloc.sv
module hop_slot_alloc
    import hop_slot_pkg::*;
#(
    parameter int HOP_MAX   = DEF_HOP_MAX,
    parameter int PAYLOAD_W = DEF_PAYLOAD_W,
    localparam int NUM_SLOTS = HOP_MAX + 1,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 gen_req,
    input  logic [PAYLOAD_W-1:0] gen_data,
    input  logic                 arr_req,
    input  logic [SLOT_W-1:0]    arr_hop,
    input  logic [PAYLOAD_W-1:0] arr_data,
    input  logic                 con_req,
    input  logic [SLOT_W-1:0]    con_slot,
    input  logic [SLOT_W-1:0]    probe_idx,
    output logic                 gen_grant,
    output logic                 gen_reject,
    output logic                 arr_grant,
    output logic                 arr_reject,
    output logic                 hop_err,
    output logic                 con_grant,
    output logic                 con_reject,
    output logic [PAYLOAD_W-1:0] con_data,
    output logic [NUM_SLOTS-1:0] free_vec,
    output logic                 probe_free
);

    logic [NUM_SLOTS-1:0]                occ;
    logic [NUM_SLOTS-1:0][PAYLOAD_W-1:0] slot_data;
    logic [NUM_SLOTS-1:0]                clr;
    wsrc_e                               wsrc [NUM_SLOTS];
    verdict_t                            gen_v, arr_v, con_v;
    verdict_t                            gen_q, arr_q, con_q;
    logic                                hop_bad, hop_err_q;
    logic [PAYLOAD_W-1:0]                picked, con_data_q;

    hop_admit #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_admit (
        .occ      (occ),
        .gen_req  (gen_req),
        .arr_req  (arr_req),
        .arr_hop  (arr_hop),
        .con_req  (con_req),
        .con_slot (con_slot),
        .gen_v    (gen_v),
        .arr_v    (arr_v),
        .con_v    (con_v),
        .hop_bad  (hop_bad),
        .clr      (clr),
        .wsrc     (wsrc)
    );

    hop_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .PAYLOAD_W(PAYLOAD_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .wsrc      (wsrc),
        .gen_data  (gen_data),
        .arr_data  (arr_data),
        .occ       (occ),
        .slot_data (slot_data)
    );

    always_comb begin
        picked     = '0;
        probe_free = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (int'(con_slot) == i)
                picked = slot_data[i];
            if (int'(probe_idx) == i)
                probe_free = ~occ[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q      <= '0;
            arr_q      <= '0;
            con_q      <= '0;
            hop_err_q  <= 1'b0;
            con_data_q <= '0;
        end else begin
            gen_q     <= gen_v;
            arr_q     <= arr_v;
            con_q     <= con_v;
            hop_err_q <= hop_bad;
            if (con_v.grant)
                con_data_q <= picked;
        end
    end

    assign gen_grant  = gen_q.grant;
    assign gen_reject = gen_q.reject;
    assign arr_grant  = arr_q.grant;
    assign arr_reject = arr_q.reject;
    assign con_grant  = con_q.grant;
    assign con_reject = con_q.reject;
    assign hop_err    = hop_err_q;
    assign con_data   = con_data_q;
    assign free_vec   = ~occ;

    // R8: every request gets exactly one answer in the next cycle
    p_gen_answer_r8: assert property (@(posedge clk) disable iff (rst)
        gen_req |=> (gen_grant ^ gen_reject));
    p_arr_answer_r8: assert property (@(posedge clk) disable iff (rst)
        arr_req |=> (arr_grant ^ arr_reject));
    p_con_answer_r8: assert property (@(posedge clk) disable iff (rst)
        con_req |=> (con_grant ^ con_reject));
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
        !(gen_req || arr_req || con_req) |=> !(gen_grant || gen_reject ||
          arr_grant || arr_reject || con_grant || con_reject));
    // R2: a generation grant leaves slot 0 occupied
    p_gen_fills_slot0_r2: assert property (@(posedge clk) disable iff (rst)
        gen_grant |-> !free_vec[0]);
    // R4: a hop error always comes with an arrival reject
    p_hop_err_rejects_r4: assert property (@(posedge clk) disable iff (rst)
        hop_err |-> (arr_reject && !arr_grant));
    // R6: with no grant at the last edge, occupancy is unchanged
    p_reject_keeps_state_r6: assert property (@(posedge clk) disable iff (rst)
        !(gen_grant || arr_grant || con_grant) |-> $stable(free_vec));
    // R5: a consumption grant frees its slot unless a packet refilled it
    p_con_frees_r5: assert property (@(posedge clk) disable iff (rst)
        (con_req && !gen_req && !arr_req && !free_vec[0] && con_slot == '0)
        |=> free_vec[0]);

endmodule

// File: tb/hop_slot_alloc_tb.sv
module hop_slot_alloc_tb;

    localparam int K  = 4;
    localparam int NS = K + 1;
    localparam int PW = 16;
    localparam int SW = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          gen_req = 0, arr_req = 0, con_req = 0;
    logic [PW-1:0] gen_data = '0, arr_data = '0;
    logic [SW-1:0] arr_hop = '0, con_slot = '0, probe_idx = '0;
    logic          gen_grant, gen_reject, arr_grant, arr_reject, hop_err;
    logic          con_grant, con_reject, probe_free;
    logic [PW-1:0] con_data;
    logic [NS-1:0] free_vec;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    int m_occ  [NS];
    int m_data [NS];

    always #4 clk = ~clk;

    hop_slot_alloc #(.HOP_MAX(K), .PAYLOAD_W(PW)) u_dut (
        .clk(clk), .rst(rst),
        .gen_req(gen_req), .gen_data(gen_data),
        .arr_req(arr_req), .arr_hop(arr_hop), .arr_data(arr_data),
        .con_req(con_req), .con_slot(con_slot), .probe_idx(probe_idx),
        .gen_grant(gen_grant), .gen_reject(gen_reject),
        .arr_grant(arr_grant), .arr_reject(arr_reject), .hop_err(hop_err),
        .con_grant(con_grant), .con_reject(con_reject), .con_data(con_data),
        .free_vec(free_vec), .probe_free(probe_free)
    );

    function automatic logic [NS-1:0] model_free();
        logic [NS-1:0] f;
        for (int i = 0; i < NS; i++) f[i] = (m_occ[i] == 0);
        return f;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request cycle: drive at negedge, compare at the following negedge.
    task automatic step(input string tag,
                        input bit g, input int gd,
                        input bit a, input int ah, input int ad,
                        input bit c, input int cs);
        bit c_ok, g_ok, a_ok, bad;
        int tgt, exp_cd;
        c_ok = c && cs < NS && m_occ[cs] != 0;
        exp_cd = c_ok ? m_data[cs] : 0;
        if (c_ok) m_occ[cs] = 0;
        g_ok = g && m_occ[0] == 0;
        bad  = a && ah >= K;
        tgt  = ah + 1;
        a_ok = a && !bad && m_occ[tgt] == 0;
        if (g_ok) begin m_occ[0] = 1; m_data[0] = gd; end
        if (a_ok) begin m_occ[tgt] = 1; m_data[tgt] = ad; end
        gen_req = g; gen_data = PW'(gd);
        arr_req = a; arr_hop = SW'(ah); arr_data = PW'(ad);
        con_req = c; con_slot = SW'(cs);
        @(posedge clk);
        @(negedge clk);
        gen_req = 0; arr_req = 0; con_req = 0;
        check({tag, " pulses"},
              64'({gen_grant, gen_reject, arr_grant, arr_reject, hop_err, con_grant, con_reject}),
              64'({g_ok, g && !g_ok, a_ok, a && !a_ok, bad, c_ok, c && !c_ok}));
        check({tag, " free_vec"}, 64'(free_vec), 64'(model_free()));
        if (c_ok) check({tag, " R11 con_data"}, 64'(con_data), 64'(exp_cd));
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        miscompares++;
        $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin m_occ[i] = 0; m_data[i] = 0; end
        repeat (3) @(negedge clk);
        check("R1 free during reset", 64'(free_vec), 64'({NS{1'b1}}));
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 64'({free_vec, gen_grant, gen_reject, arr_grant,
              arr_reject, hop_err, con_grant, con_reject}), 64'({{NS{1'b1}}, 7'b0}));

        step("R2 gen empty",        1, 'hA001, 0, 0, 0,      0, 0);
        step("R2 gen full",         1, 'hA002, 0, 0, 0,      0, 0);
        step("R3 arr hop0",         0, 0,      1, 0, 'hB001, 0, 0);
        step("R3 arr hop0 full",    0, 0,      1, 0, 'hB002, 0, 0);
        step("R3 arr top slot",     0, 0,      1, K-1, 'hB003, 0, 0);
        step("R4 arr hop=K",        0, 0,      1, K, 'hB004, 0, 0);
        step("R4 arr hop=7",        0, 0,      1, 7, 'hB005, 0, 0);
        step("R5 con slot1",        0, 0,      0, 0, 0,      1, 1);
        step("R6 con empty",        0, 0,      0, 0, 0,      1, 1);
        step("R6 con out of range", 0, 0,      0, 0, 0,      1, 6);
        step("R7 con+gen slot0",    1, 'hA003, 0, 0, 0,      1, 0);
        step("R11 con slot0",       0, 0,      0, 0, 0,      1, 0);
        step("R3 refill slot2",     0, 0,      1, 1, 'hB006, 0, 0);
        step("R7 con+arr slot2",    0, 0,      1, 1, 'hB007, 1, 2);
        step("R11 con slot2",       0, 0,      0, 0, 0,      1, 2);
        step("R10 gen+arr",         1, 'hA004, 1, 2, 'hB008, 0, 0);
        step("R5 con with all",     1, 'hA005, 1, 0, 'hB009, 1, 3);

        for (int i = 0; i < NS; i++) begin
            probe_idx = SW'(i);
            #1;
            check("R9 probe", 64'(probe_free), 64'(m_occ[i] == 0));
        end

        for (int n = 0; n < 400; n++) begin
            step("R8 mixed",
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 65535)),
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 65535)),
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)));
            probe_idx = SW'($urandom_range(0, NS - 1));
            #1;
            check("R9 probe mixed", 64'(probe_free), 64'(m_occ[int'(probe_idx)] == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule